// File: doc/BRIEF.md
# Burst-Prefetching Memory Slave

A 32-bit bus slave in front of an on-chip synchronous RAM. It serves ordinary single transfers and tagged burst transfers. A 3-bit cycle-type tag and a 2-bit burst-extension tag come with each request. For bursts, the slave latches the first address and the tags. From those it computes the address of every later beat and fetches that word ahead of time. After one fill cycle on the first beat, a read burst returns one word per clock.

The addresses a master presents on later beats do not drive the RAM. They are only compared against the predicted address. A disagreement, a reserved tag, a change of direction, or a partial byte-select on a beat that is not the last one all end the transfer with an error instead of an acknowledge. On an error nothing is written and the read data is suppressed. The last beat of a burst may narrow its byte-select. Only the selected lanes are then written, or returned non-zero.

The bus address is a word address. Wrapping bursts stay inside a block whose size is the beat count and which is aligned to that size.

Top module: `burst_prefetch_ram`

## Requirements
- R1: A single transfer (cycle type 000) is acknowledged in the second cycle of the request. The acknowledge lasts exactly one cycle, and the address is decoded anew for every such transfer.
- R2: On a write, byte lane b (bits 8b+7..8b) is stored only when sel_i[b] is 1. On an acknowledged read, lanes whose sel_i bit is 0 return zero.
- R3: In a constant burst (cycle type 001), every beat addresses the word the burst started on.
- R4: In an incrementing burst (cycle type 010) with extension 00, the word address rises by one per beat and rolls over modulo the memory depth.
- R5: With extension 01, 10 or 11, an incrementing burst wraps within an aligned block of 4, 8 or 16 words. The next address is (start − start mod W) + ((start mod W) + k) mod W.
- R6: The first beat of a burst is acknowledged in the second cycle of the request. Each further beat is acknowledged in the cycle it is presented. A beat tagged 111 is the last one, and the acknowledge stops after it.
- R7: Beats other than the last must carry all byte-select bits set. A burst whose first beat has a partial select gets an error. The last beat (tag 111) may use any select, and only those lanes are written or returned.
- R8: If a later beat presents an address other than the predicted one, or flips the write flag, that beat gets an error instead of an acknowledge. Nothing is written, read data is zero, and the burst ends.
- R9: A request whose first beat carries a reserved cycle type (011 to 110) is answered with an error, and nothing is written.
- R10: dat_o is zero in every cycle without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer request |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | AW | Word address |
| dat_i | input | 8*NB | Write data |
| sel_i | input | NB | Byte-lane select |
| cti_i | input | 3 | Cycle type: 000 single, 001 constant, 010 incrementing, 111 last beat |
| bte_i | input | 2 | Burst extension: 00 linear, 01 wrap 4, 10 wrap 8, 11 wrap 16 |
| dat_o | output | 8*NB | Read data, zero when not acknowledged |
| ack_o | output | 1 | Transfer acknowledged |
| err_o | output | 1 | Transfer rejected |

## Verification
The bench targets wrap-boundary arithmetic at every start offset for each block size. A slip there returns a word from outside the aligned block. It also targets linear bursts that cross the top of memory. It checks first-beat latency against the steady one-word-per-clock rate, which catches a design that stalls every beat or acknowledges before the prefetch lands. It injects address and direction mismatches mid-burst and partial selects on leading beats. A design that ignored these would write stray data that the final readback exposes. A narrowed final select must touch only its lanes.

// File: rtl/bpr_pkg.sv
`timescale 1ns/1ps
package bpr_pkg;
  typedef enum logic [2:0] {
    CTI_CLASSIC = 3'b000,
    CTI_CONST   = 3'b001,
    CTI_INC     = 3'b010,
    CTI_EOB     = 3'b111
  } cti_e;

  typedef enum logic [1:0] {
    BTE_LIN   = 2'b00,
    BTE_WRAP4 = 2'b01,
    BTE_WRAP8 = 2'b10,
    BTE_WRAP16 = 2'b11
  } bte_e;

  localparam int WRAP4_W  = 4;
  localparam int WRAP8_W  = 8;
  localparam int WRAP16_W = 16;

  function automatic logic cti_legal(input logic [2:0] c);
    return (c == CTI_CLASSIC) || (c == CTI_CONST) || (c == CTI_INC) || (c == CTI_EOB);
  endfunction

  function automatic logic cti_burst(input logic [2:0] c);
    return (c == CTI_CONST) || (c == CTI_INC);
  endfunction
endpackage

// File: rtl/bpr_addr_gen.sv
`timescale 1ns/1ps
module bpr_addr_gen
  import bpr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] cur_i,
  input  logic [2:0]    cti_i,
  input  logic [1:0]    bte_i,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] inc;
  logic [AW-1:0] wmask;

  assign inc = cur_i + 1'b1;

  always_comb begin
    unique case (bte_i)
      BTE_WRAP4:  wmask = AW'(WRAP4_W - 1);
      BTE_WRAP8:  wmask = AW'(WRAP8_W - 1);
      BTE_WRAP16: wmask = AW'(WRAP16_W - 1);
      default:    wmask = '1;
    endcase
  end

  // constant bursts hold; others keep the block bits and step the offset
  assign nxt_o = (cti_i == CTI_CONST) ? cur_i : ((cur_i & ~wmask) | (inc & wmask));
endmodule

// File: rtl/bpr_ram.sv
`timescale 1ns/1ps
module bpr_ram #(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [NB-1:0]   be_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [NB*8-1:0] wdata_i,
  input  logic            re_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [NB*8-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [NB*8-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < NB; b++) begin
        if (be_i[b]) mem[waddr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
      end
    end
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/bpr_lane_mask.sv
`timescale 1ns/1ps
module bpr_lane_mask #(
  parameter int NB = 4
) (
  input  logic [NB*8-1:0] data_i,
  input  logic [NB-1:0]   sel_i,
  input  logic            en_i,
  output logic [NB*8-1:0] data_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign data_o[b*8 +: 8] = (en_i && sel_i[b]) ? data_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/burst_prefetch_ram.sv
`timescale 1ns/1ps
module burst_prefetch_ram
  import bpr_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cyc_i,
  input  logic            stb_i,
  input  logic            we_i,
  input  logic [AW-1:0]   adr_i,
  input  logic [NB*8-1:0] dat_i,
  input  logic [NB-1:0]   sel_i,
  input  logic [2:0]      cti_i,
  input  logic [1:0]      bte_i,
  output logic [NB*8-1:0] dat_o,
  output logic            ack_o,
  output logic            err_o
);
  localparam int DW = NB * 8;

  logic          pend_q, we_q, bad_q;
  logic [AW-1:0] exp_q, nxt_adr, ram_raddr;
  logic [2:0]    type_q;
  logic [1:0]    bte_q;
  logic          start, hs, burst_q, beat_ok, start_bad, cont, ram_re;
  logic [DW-1:0] ram_q;

  assign start   = cyc_i && stb_i && !pend_q;
  assign hs      = cyc_i && stb_i && pend_q;
  assign burst_q = cti_burst(type_q);

  always_comb start_bad = !cti_legal(cti_i) || (cti_burst(cti_i) && !(&sel_i));

  // later beats are checked against the prediction, never decoded
  always_comb begin
    beat_ok = !bad_q && (adr_i == exp_q) && (we_i == we_q);
    if (burst_q) beat_ok = beat_ok && ((cti_i == CTI_EOB) || ((cti_i == type_q) && (&sel_i)));
    else         beat_ok = beat_ok && (cti_i == type_q);
  end

  assign ack_o = hs && beat_ok;
  assign err_o = hs && !beat_ok;
  assign cont  = ack_o && burst_q && (cti_i != CTI_EOB);

  assign ram_re    = start || cont;
  assign ram_raddr = start ? adr_i : nxt_adr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      we_q   <= 1'b0;
      bad_q  <= 1'b0;
      exp_q  <= '0;
      type_q <= CTI_CLASSIC;
      bte_q  <= BTE_LIN;
    end else if (start) begin
      pend_q <= 1'b1;
      exp_q  <= adr_i;
      type_q <= cti_i;
      bte_q  <= bte_i;
      we_q   <= we_i;
      bad_q  <= start_bad;
    end else if (pend_q) begin
      if (!cyc_i || err_o) begin
        pend_q <= 1'b0;
      end else if (ack_o) begin
        pend_q <= cont;
        if (cont) exp_q <= nxt_adr;
      end
    end
  end

  bpr_addr_gen #(.AW(AW)) u_addr_gen (
    .cur_i (exp_q),
    .cti_i (type_q),
    .bte_i (bte_q),
    .nxt_o (nxt_adr)
  );

  bpr_ram #(.AW(AW), .NB(NB)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ack_o && we_i),
    .be_i    (sel_i),
    .waddr_i (exp_q),
    .wdata_i (dat_i),
    .re_i    (ram_re),
    .raddr_i (ram_raddr),
    .rdata_o (ram_q)
  );

  bpr_lane_mask #(.NB(NB)) u_lane_mask (
    .data_i (ram_q),
    .sel_i  (sel_i),
    .en_i   (ack_o && !we_i),
    .data_o (dat_o)
  );

  // R1
  classic_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && cti_i == CTI_CLASSIC) |=> (!ack_o && !err_o));

  // R3
  const_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && cti_i == CTI_CONST) |=> (!ack_o || adr_i == $past(adr_i)));

  // R4
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && cti_i == CTI_INC && bte_q == BTE_LIN) |=> (!ack_o || adr_i == AW'($past(adr_i) + 1'b1)));

  // R6
  zero_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && cti_burst(cti_i)) |=> (!(cyc_i && stb_i) || ack_o || err_o));

  // R8
  err_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !ack_o);

  // R9
  reserved_cti_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !cti_legal(cti_i)) |=> (!(cyc_i && stb_i) || err_o));

  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (dat_o == '0));
endmodule

// File: tb/burst_prefetch_ram_tb.sv
`timescale 1ns/1ps
module burst_prefetch_ram_tb;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc, stb, we;
  logic [AW-1:0] adr;
  logic [31:0] dat, dat_o;
  logic [3:0] sel;
  logic [2:0] cti;
  logic [1:0] bte;
  logic ack, err;

  logic [31:0] model [DEPTH];
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  burst_prefetch_ram #(.AW(AW), .NB(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(dat), .sel_i(sel), .cti_i(cti), .bte_i(bte),
    .dat_o(dat_o), .ack_o(ack), .err_o(err)
  );

  function automatic logic [31:0] lmask(input logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  function automatic logic [31:0] pat(input logic [AW-1:0] a, input int salt);
    return (32'(salt) * 32'h0100_0193) ^ (32'(a) * 32'h0001_0101) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] st, input int k,
                                          input logic [2:0] ty, input logic [1:0] b);
    int w, base;
    if (ty == 3'b001) return st;
    if (b == 2'b00) return AW'((int'(st) + k) % DEPTH);
    w = 2 << b;
    base = int'(st) - (int'(st) % w);
    return AW'(base + ((int'(st) % w) + k) % w);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cyc = 0; stb = 0; we = 0; adr = '0; dat = '0; sel = '0; cti = '0; bte = '0;
  endtask

  task automatic drv(input bit w_, input logic [AW-1:0] a_, input logic [31:0] d_,
                     input logic [3:0] s_, input logic [2:0] c_, input logic [1:0] b_);
    cyc = 1; stb = 1; we = w_; adr = a_; dat = d_; sel = s_; cti = c_; bte = b_;
  endtask

  task automatic classic(input bit w, input logic [AW-1:0] a, input logic [3:0] s,
                         input int salt, input string tag);
    @(posedge clk); #1;
    drv(w, a, pat(a, salt), s, 3'b000, 2'b00);
    @(negedge clk);
    chk({tag, " R1 wait"}, {30'd0, ack, err}, 32'd0);
    @(negedge clk);
    chk({tag, " R1 ack"}, {30'd0, ack, err}, 32'd2);
    if (w) model[a] = (model[a] & ~lmask(s)) | (pat(a, salt) & lmask(s));
    else chk({tag, " R2 data"}, dat_o, model[a] & lmask(s));
    @(posedge clk); #1;
    idle();
    @(negedge clk);
    chk({tag, " R1 single ack / R10 idle"}, {ack, err, 30'd0} | dat_o, 32'd0);
  endtask

  task automatic beat(input bit w, input logic [AW-1:0] st, input int n, input logic [2:0] ty,
                      input logic [1:0] b, input logic [3:0] lsel, input int bad, input bit bad_we,
                      input int salt, input int k);
    logic [AW-1:0] a;
    a = baddr(st, k, ty, b);
    if (k == bad && !bad_we) a = a + 1'b1;
    drv(w ^ (bad_we && k == bad), a, pat(baddr(st, k, ty, b), salt + k),
        (k == n - 1) ? lsel : 4'hF, (k == n - 1) ? 3'b111 : ty, b);
  endtask

  task automatic burst(input bit w, input logic [AW-1:0] st, input int n, input logic [2:0] ty,
                       input logic [1:0] b, input logic [3:0] lsel, input int bad, input bit bad_we,
                       input int salt, input string tag);
    logic [AW-1:0] a;
    logic [3:0] s;
    @(posedge clk); #1;
    beat(w, st, n, ty, b, lsel, bad, bad_we, salt, 0);
    @(negedge clk);
    chk({tag, " R6 first-beat fill"}, {30'd0, ack, err}, 32'd0);
    for (int k = 0; k < n; k++) begin
      a = baddr(st, k, ty, b);
      s = (k == n - 1) ? lsel : 4'hF;
      if (k > 0) begin
        @(posedge clk); #1;
        beat(w, st, n, ty, b, lsel, bad, bad_we, salt, k);
      end
      @(negedge clk);
      if (k == bad) begin
        chk({tag, " R8 err"}, {30'd0, ack, err}, 32'd1);
        chk({tag, " R8 discard"}, dat_o, 32'd0);
        break;
      end
      chk({tag, " R6 beat ack"}, {30'd0, ack, err}, 32'd2);
      if (w) model[a] = (model[a] & ~lmask(s)) | (pat(a, salt + k) & lmask(s));
      else chk({tag, " R7 beat data"}, dat_o, model[a] & lmask(s));
    end
    @(posedge clk); #1;
    idle();
    @(negedge clk);
    chk({tag, " R6 end"}, {30'd0, ack, err}, 32'd0);
  endtask

  task automatic bad_start(input bit w, input logic [2:0] c, input logic [3:0] s,
                           input logic [AW-1:0] a, input string tag);
    @(posedge clk); #1;
    drv(w, a, 32'hDEAD_BEEF, s, c, 2'b00);
    @(negedge clk);
    chk({tag, " wait"}, {30'd0, ack, err}, 32'd0);
    @(negedge clk);
    chk({tag, " err"}, {30'd0, ack, err}, 32'd1);
    chk({tag, " R10 data zero"}, dat_o, 32'd0);
    @(posedge clk); #1;
    idle();
    @(negedge clk);
  endtask

  task automatic readback(input string tag);
    for (int a = 0; a < DEPTH; a++) classic(1'b0, AW'(a), 4'hF, 0, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset ack/err/data", {ack, err, 30'd0} | dat_o, 32'd0);
    rst_n = 1'b1;

    // R1: fill the memory with single writes, then read it back
    for (int a = 0; a < DEPTH; a++) classic(1'b1, AW'(a), 4'hF, 1, "R1 fill");
    readback("R1 read");

    // R2: every byte-select pattern on writes and complementary reads
    for (int s = 0; s < 16; s++) begin
      classic(1'b1, AW'(s), 4'(s), 7, "R2 wr");
      classic(1'b0, AW'(s), 4'(~s), 0, "R2 rd");
      classic(1'b0, AW'(s), 4'hF, 0, "R2 rd full");
    end

    // R4 R5 R7: read bursts from every start offset for each extension
    for (int b = 0; b < 4; b++) begin
      for (int st = 0; st < DEPTH; st++) begin
        burst(1'b0, AW'(st), (b == 0) ? 7 : (2 << b), 3'b010, 2'(b), 4'(st),
              -1, 1'b0, 0, (b == 0) ? "R4 rd linear" : "R5 rd wrap");
      end
    end

    // R3: constant read bursts
    for (int st = 0; st < DEPTH; st += 7)
      burst(1'b0, AW'(st), 5, 3'b001, 2'b00, 4'hC, -1, 1'b0, 0, "R3 rd const");

    // R3 R7: constant write bursts with a narrowed final select
    burst(1'b1, AW'(9), 4, 3'b001, 2'b00, 4'h6, -1, 1'b0, 40, "R3 wr const");
    burst(1'b1, AW'(50), 3, 3'b001, 2'b11, 4'h1, -1, 1'b0, 44, "R3 wr const");

    // R4 R5 R7: write bursts across extensions and boundaries
    for (int b = 0; b < 4; b++) begin
      burst(1'b1, AW'(0),  (b == 0) ? 7 : (2 << b), 3'b010, 2'(b), 4'hA, -1, 1'b0, 60 + b, "R5 wr");
      burst(1'b1, AW'(5),  (b == 0) ? 7 : (2 << b), 3'b010, 2'(b), 4'h5, -1, 1'b0, 70 + b, "R5 wr");
      burst(1'b1, AW'(13), (b == 0) ? 7 : (2 << b), 3'b010, 2'(b), 4'h3, -1, 1'b0, 80 + b, "R5 wr");
      burst(1'b1, AW'(62), (b == 0) ? 7 : (2 << b), 3'b010, 2'(b), 4'hF, -1, 1'b0, 90 + b, "R4 wr top");
    end

    // R6: single-beat burst tagged as last
    burst(1'b0, AW'(33), 1, 3'b010, 2'b00, 4'hF, -1, 1'b0, 0, "R6 one beat");

    // R8: address mismatch and direction flip mid-burst
    burst(1'b0, AW'(10), 6, 3'b010, 2'b00, 4'hF, 3, 1'b0, 0, "R8 rd addr");
    burst(1'b1, AW'(20), 8, 3'b010, 2'b10, 4'hF, 2, 1'b0, 100, "R8 wr addr");
    burst(1'b1, AW'(40), 4, 3'b010, 2'b01, 4'hF, 1, 1'b1, 110, "R8 wr dir");
    burst(1'b1, AW'(30), 4, 3'b001, 2'b00, 4'hF, 2, 1'b0, 120, "R8 wr const addr");

    // R9: reserved cycle types rejected, no write
    for (int c = 3; c < 7; c++) bad_start(1'b1, 3'(c), 4'hF, AW'(c), "R9 reserved");
    // R7: partial select on a leading burst beat rejected, no write
    bad_start(1'b1, 3'b001, 4'h3, AW'(44), "R7 partial start const");
    bad_start(1'b1, 3'b010, 4'hE, AW'(45), "R7 partial start inc");

    // R2 R7 R8 R9: final memory image matches the model
    readback("R7 R8 R9 final image");

    summary();
  end
endmodule